// File: doc/BRIEF.md
# Run-Time Reconfigurable Approximate Multiplier

This block multiplies an 8-bit unsigned weight by an 8-bit unsigned activation and returns a 16-bit product one clock cycle later. The product is built from a grid of partial-product bits, one for each pair of weight and activation bits. Each bit in the low-order columns of the grid passes through a switch. A switch either forwards the real partial-product bit or drives a fixed constant in its place. Holding bits constant removes toggling in the low columns at a small, bounded cost in accuracy.

The accuracy level is chosen for each operand pair from the weight alone. Two thresholds, a lower and an upper, split the weight axis into three bands. The lower band gets the coarsest level, the middle band gets the intermediate level, and the upper band is computed exactly. A layer controller loads the thresholds through a one-cycle write port before each layer. The level used for each product is returned with the product, so the consumer can track the error.

Top module: `approx_mult_rt`

## Requirements
- R1: After reset, out_valid is 0 and both thresholds are 0. Every weight therefore falls in the exact band, and out_level reads 0.
- R2: At level 0 (out_level = 0), out_product equals weight × activation exactly.
- R3: At level 1 (out_level = 1), every partial-product bit weight[i]&act[j] with i+j < 2 is forced to 0. The product is the exact product minus those bits' weighted values. It never exceeds the exact product, falls short of it by at most 5, and has bits [1:0] equal to 0.
- R4: At level 2 (out_level = 2), every partial-product bit with i+j < 4 is forced to 0, except weight[0]&act[3], which is forced to 1. The product is the exact product minus the dropped bits plus 8, so a zero weight still yields 8. Bits [2:0] of the product are 0, and the exact product minus the result lies between -8 and 41.
- R5: The level is chosen by unsigned 8-bit compares. A weight below the lower threshold gives level 2. Otherwise, a weight below the upper threshold gives level 1. Any other weight gives level 0. The lower compare wins even when the lower threshold exceeds the upper one.
- R6: A config write with cfg_we = 1 and cfg_sel = 0 loads the lower threshold. A write with cfg_sel = 1 loads the upper threshold. A new value applies to operands accepted in later cycles. An operand accepted in the same cycle as the write uses the old value.
- R7: out_valid is 1 in the cycle after each cycle with in_valid = 1, and 0 otherwise. Back-to-back operands yield back-to-back results, and each result carries its own level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 1 | 0 selects the lower threshold, 1 selects the upper threshold |
| cfg_data | input | 8 | Threshold value to write |
| in_valid | input | 1 | Operand pair is present |
| in_weight | input | 8 | Unsigned weight operand |
| in_act | input | 8 | Unsigned activation operand |
| out_valid | output | 1 | Result is present |
| out_product | output | 16 | Product, exact or approximate |
| out_level | output | 2 | Accuracy level used: 0 exact, 1 intermediate, 2 coarse |

## Verification
The directed weights sit on each side of both thresholds. They show whether the band compares are strict and in the right priority, and a reversed threshold pair shows which compare wins. Zero and all-ones operands at each level separate the dropped columns from the forced bias bit: a zero weight must give 8 at level 2 and 0 at level 1. A threshold write issued in the same cycle as an operand shows whether the new value leaks into that operand. Random operands, with thresholds reloaded every few dozen vectors, compare every product bit for bit against a model built from the column rules and also against the error bands.

// File: rtl/approx_mult_pkg.sv
package approx_mult_pkg;
  typedef enum logic [1:0] {
    LVL_EXACT = 2'd0,
    LVL_MID   = 2'd1,
    LVL_LOW   = 2'd2
  } acc_lvl_e;
endpackage

// File: rtl/pp_switch.sv
// One gated partial-product bit: forwards the data bit or holds a fixed value.
module pp_switch #(
  parameter bit FORCE_VAL = 1'b0
) (
  input  logic din,
  input  logic force_en,
  output logic dout
);
  assign dout = force_en ? FORCE_VAL : din;
endmodule

// File: rtl/lvl_select.sv
// Weight band decode: strict unsigned compares, lower band has priority.
module lvl_select
  import approx_mult_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] weight,
  input  logic [W-1:0] thr_lo,
  input  logic [W-1:0] thr_hi,
  output acc_lvl_e     lvl
);
  logic below_lo;
  logic below_hi;

  assign below_lo = (weight < thr_lo);
  assign below_hi = (weight < thr_hi);

  always_comb begin
    if (below_lo)      lvl = LVL_LOW;
    else if (below_hi) lvl = LVL_MID;
    else               lvl = LVL_EXACT;
  end
endmodule

// File: rtl/approx_mult_core.sv
// Partial-product array with switches on the low columns, summed by column weight.
module approx_mult_core
  import approx_mult_pkg::*;
#(
  parameter int W        = 8,
  parameter int MID_COLS = 2,
  parameter int LOW_COLS = 4,
  parameter int BIAS_COL = 3
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  acc_lvl_e       lvl,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;
  localparam int NB = W * W;

  logic [NB-1:0] pp_sw;
  logic          lvl_low;
  logic          lvl_mid;

  assign lvl_low = (lvl == LVL_LOW);
  assign lvl_mid = (lvl == LVL_MID);

  for (genvar gi = 0; gi < W; gi++) begin : g_row
    for (genvar gj = 0; gj < W; gj++) begin : g_col
      localparam int COL     = gi + gj;
      localparam bit IN_MID  = (COL < MID_COLS);
      localparam bit IS_BIAS = (gi == 0) && (gj == BIAS_COL);
      logic raw;
      assign raw = a[gi] & b[gj];
      if (COL < LOW_COLS) begin : g_sw
        logic fen;
        assign fen = lvl_low | (lvl_mid & IN_MID);
        pp_switch #(.FORCE_VAL(IS_BIAS)) u_sw (
          .din      (raw),
          .force_en (fen),
          .dout     (pp_sw[gi*W+gj])
        );
      end else begin : g_pass
        assign pp_sw[gi*W+gj] = raw;
      end
    end
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        prod = prod + (PW'(pp_sw[i*W+j]) << (i + j));
      end
    end
  end
endmodule

// File: rtl/approx_mult_rt.sv
module approx_mult_rt
  import approx_mult_pkg::*;
#(
  parameter int W        = 8,
  parameter int MID_COLS = 2,
  parameter int LOW_COLS = 4,
  parameter int BIAS_COL = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic           cfg_sel,
  input  logic [W-1:0]   cfg_data,
  input  logic           in_valid,
  input  logic [W-1:0]   in_weight,
  input  logic [W-1:0]   in_act,
  output logic           out_valid,
  output logic [2*W-1:0] out_product,
  output logic [1:0]     out_level
);
  localparam int PW = 2 * W;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // band thresholds
  logic [W-1:0] thr_lo_q, thr_lo_d;
  logic [W-1:0] thr_hi_q, thr_hi_d;

  always_comb begin
    thr_lo_d = thr_lo_q;
    thr_hi_d = thr_hi_q;
    if (cfg_we && !cfg_sel) thr_lo_d = cfg_data;
    if (cfg_we &&  cfg_sel) thr_hi_d = cfg_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      thr_lo_q <= '0;
      thr_hi_q <= '0;
    end else begin
      thr_lo_q <= thr_lo_d;
      thr_hi_q <= thr_hi_d;
    end
  end

  // level decode and switched multiplier
  acc_lvl_e      lvl_c;
  logic [PW-1:0] prod_c;

  lvl_select #(.W(W)) u_sel (
    .weight (in_weight),
    .thr_lo (thr_lo_q),
    .thr_hi (thr_hi_q),
    .lvl    (lvl_c)
  );

  approx_mult_core #(
    .W        (W),
    .MID_COLS (MID_COLS),
    .LOW_COLS (LOW_COLS),
    .BIAS_COL (BIAS_COL)
  ) u_core (
    .a    (in_weight),
    .b    (in_act),
    .lvl  (lvl_c),
    .prod (prod_c)
  );

  // result stage
  logic          vld_q;
  logic [PW-1:0] prod_q;
  logic [1:0]    lvl_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) vld_q <= 1'b0;
    else            vld_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      prod_q <= prod_c;
      lvl_q  <= lvl_c;
    end
  end

  assign out_valid   = vld_q;
  assign out_product = prod_q;
  assign out_level   = lvl_q;
endmodule

// File: rtl/approx_mult_rt_chk.sv
module approx_mult_rt_chk #(
  parameter int W        = 8,
  parameter int MID_COLS = 2,
  parameter int BIAS_COL = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [W-1:0]   in_weight,
  input logic [W-1:0]   in_act,
  input logic           out_valid,
  input logic [2*W-1:0] out_product,
  input logic [1:0]     out_level
);
  localparam int PW = 2 * W;

  function automatic int col_bound(input int ncols);
    int s;
    s = 0;
    for (int c = 0; c < ncols; c++) s += ((c + 1 < W) ? c + 1 : W) << c;
    return s;
  endfunction

  localparam logic [PW-1:0] MID_BOUND = PW'(col_bound(MID_COLS));
  localparam logic [PW-1:0] LOW_MASK  = PW'((1 << BIAS_COL) - 1);

  logic [PW-1:0] exact_q;
  always_ff @(posedge clk) begin
    if (in_valid) exact_q <= PW'(in_weight) * PW'(in_act);
  end

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_exact_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_level == 2'd0) |-> (out_product == exact_q));

  assert_mid_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_level == 2'd1) |->
      ((out_product <= exact_q) && ((exact_q - out_product) <= MID_BOUND)));

  assert_low_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_level == 2'd2) |-> ((out_product & LOW_MASK) == '0));

  assert_level_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_level != 2'd3));
endmodule

bind approx_mult_rt approx_mult_rt_chk #(
  .W        (W),
  .MID_COLS (MID_COLS),
  .BIAS_COL (BIAS_COL)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .in_valid    (in_valid),
  .in_weight   (in_weight),
  .in_act      (in_act),
  .out_valid   (out_valid),
  .out_product (out_product),
  .out_level   (out_level)
);

// File: tb/sim_approx_mult_rt.sv
`timescale 1ns/1ps
module sim_approx_mult_rt;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic        cfg_sel;
  logic [7:0]  cfg_data;
  logic        in_valid;
  logic [7:0]  in_weight;
  logic [7:0]  in_act;
  logic        out_valid;
  logic [15:0] out_product;
  logic [1:0]  out_level;

  int n_chk;
  int n_bad;
  logic [7:0] t_lo;
  logic [7:0] t_hi;

  approx_mult_rt u0 (
    .clk (clk), .rst_n (rst_n),
    .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_data (cfg_data),
    .in_valid (in_valid), .in_weight (in_weight), .in_act (in_act),
    .out_valid (out_valid), .out_product (out_product), .out_level (out_level)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [1:0] ref_level(input logic [7:0] w);
    if (w < t_lo) return 2'd2;
    if (w < t_hi) return 2'd1;
    return 2'd0;
  endfunction

  // R2/R3/R4 column rules
  function automatic logic [15:0] ref_product(input logic [7:0] w, input logic [7:0] x,
                                              input logic [1:0] lv);
    int p;
    p = int'(w) * int'(x);
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        if (w[i] && x[j]) begin
          if (lv == 2'd1 && (i + j) < 2) p -= (1 << (i + j));
          if (lv == 2'd2 && (i + j) < 4) p -= (1 << (i + j));
        end
      end
    end
    if (lv == 2'd2) p += 8;
    return p[15:0];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_result(input logic [7:0] w, input logic [7:0] x,
                              input logic [1:0] lv);
    int ex;
    int err;
    check("R7 out_valid", int'(out_valid), 1);
    check("R5 out_level", int'(out_level), int'(lv));
    check(lv == 2'd0 ? "R2 product" : (lv == 2'd1 ? "R3 product" : "R4 product"),
          int'(out_product), int'(ref_product(w, x, lv)));
    ex  = int'(w) * int'(x);
    err = ex - int'(out_product);
    if (lv == 2'd1) check("R3 error band", int'(err >= 0 && err <= 5), 1);
    if (lv == 2'd2) check("R4 error band", int'(err >= -8 && err <= 41), 1);
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) t_hi = v; else t_lo = v;
  endtask

  task automatic apply(input logic [7:0] w, input logic [7:0] x);
    logic [1:0] lv;
    @(negedge clk);
    in_valid = 1'b1; in_weight = w; in_act = x;
    lv = ref_level(w);
    @(negedge clk);
    in_valid = 1'b0;
    check_result(w, x, lv);
    @(negedge clk);
    check("R7 idle valid", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [1:0] lv_a;
    logic [1:0] lv_b;
    n_chk = 0; n_bad = 0; t_lo = 8'd0; t_hi = 8'd0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_data = '0;
    in_valid = 1'b0; in_weight = '0; in_act = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);

    // R1: thresholds reset to 0, so everything is exact
    apply(8'd0, 8'd0);
    apply(8'd255, 8'd255);
    apply(8'd13, 8'd201);

    // R5/R6 band edges
    cfg_write(1'b0, 8'd64);
    cfg_write(1'b1, 8'd160);
    apply(8'd63, 8'd255);
    apply(8'd64, 8'd255);
    apply(8'd159, 8'd3);
    apply(8'd160, 8'd255);
    apply(8'd0, 8'd0);     // R4: zero weight at level 2 gives 8
    apply(8'd0, 8'd255);
    apply(8'd1, 8'd1);     // R4: dropped column-0 bit
    apply(8'd65, 8'd3);    // R3: columns 0 and 1 dropped
    apply(8'd255, 8'd0);

    // R6: write in the same cycle as an operand uses the old threshold
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_data = 8'd200;
    in_valid = 1'b1; in_weight = 8'd100; in_act = 8'd7;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    check_result(8'd100, 8'd7, 2'd1);
    t_lo = 8'd200;
    apply(8'd100, 8'd7);

    // R5: reversed thresholds, lower compare wins
    cfg_write(1'b1, 8'd50);
    apply(8'd100, 8'd77);
    apply(8'd220, 8'd77);
    apply(8'd30, 8'd77);

    // R7: back-to-back operands at different levels
    @(negedge clk);
    in_valid = 1'b1; in_weight = 8'd10; in_act = 8'd250;
    lv_a = ref_level(8'd10);
    @(negedge clk);
    in_weight = 8'd240; in_act = 8'd99;
    lv_b = ref_level(8'd240);
    check_result(8'd10, 8'd250, lv_a);
    @(negedge clk);
    in_valid = 1'b0;
    check_result(8'd240, 8'd99, lv_b);
    @(negedge clk);
    check("R7 idle after burst", int'(out_valid), 0);

    // random operands with periodic threshold reloads
    for (int k = 0; k < 400; k++) begin
      if (k % 40 == 0) begin
        cfg_write(1'b0, 8'($urandom_range(0, 120)));
        cfg_write(1'b1, 8'($urandom_range(100, 255)));
      end
      apply(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule